// File: doc/BRIEF.md
# Configuration Self-Load and Mode Controller

This block decides, right after reset, how a clock generator comes up. It samples a mode input once. A high level selects run mode. The block then reads a sixteen-byte configuration from a byte-wide store, lowest address first. It writes each byte into a 128-bit control vector. While the copy is in progress, every clock output is held low.

When the copy ends, two shared pins take on new roles. The first becomes an active-high power-down request. The second becomes an active-low output enable. A low mode level selects program mode instead. In program mode the control vector stays cleared, which passes the undivided reference to every output, and the shared pins are handed to the serial programming interface.

The store is read through an address output and a data input. The data input must follow the address combinationally. Each byte is held on the bus for `BYTE_GAP` cycles and captured on the last cycle of that interval. With the default value, the whole copy lasts about 89,000 reference cycles.

Top module: `cfg_loader`

## Requirements
- R1: The mode input is sampled on the first clock edge after reset is released. Later changes to the mode input have no effect until the next reset.
- R2: In run mode the copy takes exactly 16*BYTE_GAP edges after the sampling edge. `load_done` rises on the last of these edges and stays high until reset.
- R3: During the copy, `store_addr` steps through 0 to 15 in increasing order, spending BYTE_GAP cycles on each address. Byte k lands in `cfg_q[8k+7:8k]`.
- R4: `hold_low` is high from reset until the copy completes in run mode.
- R5: An all-zero store gives `cfg_q` equal to zero after the copy, with `hold_low` released.
- R6: After the copy in run mode, `chan_off[3:0]` equals `cfg_q[123:120]` (channels A to D) when `dual0_in` is high, and zero otherwise. `out_en` follows `dual1_in`.
- R7: After the copy in run mode, `osc_off` is high exactly when `dual0_in` is high and all of `cfg_q[126:120]` are set. Bits 120 to 123 are the post-divider power-down bits and bits 124 to 126 are the PLL power-down bits.
- R8: In program mode, `cfg_q` stays zero, `serial_route` is high and `hold_low` is low, whatever the store holds.
- R9: In program mode, `chan_off` is zero, `osc_off` is low and `out_en` is high, whatever levels the shared pins carry.
- R10: In run mode, `serial_route` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_in | input | 1 | Mode select, sampled once: 1 = run, 0 = program |
| dual0_in | input | 1 | First shared pin level (power-down request in run mode) |
| dual1_in | input | 1 | Second shared pin level (output enable in run mode) |
| store_addr | output | 4 | Byte address presented to the configuration store |
| store_data | input | 8 | Byte returned by the store for `store_addr` |
| cfg_q | output | 128 | Control register vector |
| hold_low | output | 1 | Forces all clock outputs low |
| serial_route | output | 1 | Routes the shared pins to the serial interface |
| chan_off | output | 4 | Post-divider power-down for channels A to D |
| osc_off | output | 1 | Reference oscillator power-down |
| out_en | output | 1 | Output driver enable |
| load_done | output | 1 | Copy has completed |

## Verification
The first edge after reset fixes the mode. From that edge onward, the store address advances once every BYTE_GAP edges. `load_done`, the final `cfg_q` and the release of `hold_low` all appear on the edge 16*BYTE_GAP after the sampling edge. The bench counts edges from the release of reset and samples 2 ns after each edge. It checks the address at the start of every interval, and checks that the copy is still pending one interval before the end. The pin-derived outputs are combinational, so they are checked 1 ns after the pins change.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int BYTE_GAP = 5563
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_in,
  input  logic         dual0_in,
  input  logic         dual1_in,
  output logic [3:0]   store_addr,
  input  logic [7:0]   store_data,
  output logic [127:0] cfg_q,
  output logic         hold_low,
  output logic         serial_route,
  output logic [3:0]   chan_off,
  output logic         osc_off,
  output logic         out_en,
  output logic         load_done
);
  localparam int NBYTES = 16;
  localparam int GW = $clog2(BYTE_GAP + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(BYTE_GAP - 1);

  typedef enum logic [1:0] {ST_LATCH, ST_LOAD, ST_RUN, ST_PROG} st_t;

  st_t           st;
  logic [GW-1:0] gap_cnt;
  logic [3:0]    idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_LATCH;
      gap_cnt   <= '0;
      idx       <= '0;
      cfg_q     <= '0;
      load_done <= 1'b0;
    end else begin
      case (st)
        ST_LATCH: st <= mode_in ? ST_LOAD : ST_PROG;
        ST_LOAD: begin
          if (gap_cnt == GAP_LAST) begin
            cfg_q[{idx, 3'b000} +: 8] <= store_data;
            gap_cnt <= '0;
            if (idx == 4'(NBYTES - 1)) begin
              st        <= ST_RUN;
              load_done <= 1'b1;
            end else begin
              idx <= idx + 4'd1;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_PROG: cfg_q <= '0;
        default: ;
      endcase
    end
  end

  wire run_live = (st == ST_RUN);
  wire pd_req   = run_live & dual0_in;

  assign store_addr   = idx;
  assign hold_low     = (st == ST_LATCH) | (st == ST_LOAD);
  assign serial_route = (st == ST_PROG);
  assign chan_off     = pd_req ? cfg_q[123:120] : 4'b0000;
  assign osc_off      = pd_req & (&cfg_q[126:120]);
  assign out_en       = run_live ? dual1_in : 1'b1;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   store_addr,
  input logic [127:0] cfg_q,
  input logic         hold_low,
  input logic         serial_route,
  input logic [3:0]   chan_off,
  input logic         osc_off,
  input logic         out_en,
  input logic         load_done
);
  a_r1_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    serial_route |=> serial_route);
  a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);
  a_r3_addr_order: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_low && !$stable(store_addr)) |-> store_addr == 4'($past(store_addr) + 4'd1));
  a_r4_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    hold_low |-> !load_done);
  a_r8_prog_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    serial_route |-> (cfg_q == '0 && !hold_low));
  a_r9_prog_pins_inert: assert property (@(posedge clk) disable iff (!rst_n)
    serial_route |-> (chan_off == 4'b0000 && !osc_off && out_en));
  a_r7_osc_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off |-> chan_off == 4'hF);
  a_r10_run_no_serial: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !serial_route);
endmodule

bind cfg_loader cfg_loader_chk u_chk (.*);

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;
  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_in = 1'b1, dual0_in = 1'b0, dual1_in = 1'b1;
  logic [3:0] store_addr;
  logic [7:0] store_data;
  logic [127:0] cfg_q;
  logic hold_low, serial_route, osc_off, out_en, load_done;
  logic [3:0] chan_off;
  logic [7:0] mem [16];

  int checks = 0, fails = 0;
  bit ended = 0;

  always #4 clk = ~clk;
  assign store_data = mem[store_addr];

  cfg_loader #(.BYTE_GAP(GAP)) u0 (.*);

  function automatic logic [127:0] exp_cfg();
    logic [127:0] v = '0;
    for (int k = 0; k < 16; k++) v[8*k +: 8] = mem[k];
    return v;
  endfunction

  function automatic logic [3:0] exp_chan(logic [127:0] c, logic p);
    return p ? c[123:120] : 4'b0000;
  endfunction

  function automatic logic exp_osc(logic [127:0] c, logic p);
    return p & (&c[126:120]);
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset(logic m);
    @(negedge clk);
    rst_n = 1'b0;
    mode_in = m;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(hold_low == 1'b1 && load_done == 1'b0, "R4 reset", {hold_low, load_done}, 2'b10);
    chk(cfg_q == '0, "R8 reset cfg", cfg_q, '0);
  endtask

  task automatic run_trial();
    logic [127:0] e;
    do_reset(1'b1);
    tick(1);
    mode_in = 1'b0;  // R1: changes after sampling are ignored
    for (int k = 0; k < 16; k++) begin
      chk(store_addr == 4'(k), "R3 addr", store_addr, k);
      chk(hold_low && !load_done, "R2 pending", {hold_low, load_done}, 2'b10);
      tick(GAP);
    end
    e = exp_cfg();
    chk(load_done == 1'b1, "R2 done", load_done, 1);
    chk(hold_low == 1'b0, "R4 released", hold_low, 0);
    chk(cfg_q == e, "R3 cfg", cfg_q, e);
    chk(serial_route == 1'b0, "R10 run route", serial_route, 0);
    for (int i = 0; i < 4; i++) begin
      dual0_in = 1'($urandom);
      dual1_in = 1'($urandom);
      #1;
      chk(chan_off == exp_chan(e, dual0_in), "R6 chan_off", chan_off, exp_chan(e, dual0_in));
      chk(out_en == dual1_in, "R6 out_en", out_en, dual1_in);
      chk(osc_off == exp_osc(e, dual0_in), "R7 osc_off", osc_off, exp_osc(e, dual0_in));
    end
    tick(5);
    chk(load_done && !serial_route && !hold_low, "R1 mode kept", {load_done, serial_route, hold_low}, 3'b100);
  endtask

  task automatic prog_trial();
    do_reset(1'b0);
    tick(1);
    mode_in = 1'b1;  // R1: changes after sampling are ignored
    chk(serial_route == 1'b1, "R8 route", serial_route, 1);
    chk(hold_low == 1'b0, "R8 hold", hold_low, 0);
    for (int i = 0; i < 4; i++) begin
      dual0_in = 1'($urandom);
      dual1_in = 1'($urandom);
      #1;
      chk(chan_off == 4'b0000 && !osc_off && out_en, "R9 pins inert", {chan_off, osc_off, out_en}, 6'b000001);
    end
    tick(20 * GAP);
    chk(cfg_q == '0, "R8 cfg zero", cfg_q, '0);
    chk(load_done == 1'b0 && serial_route == 1'b1, "R1 prog kept", {load_done, serial_route}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < 16; k++) mem[k] = 8'($urandom);
      run_trial();
    end
    for (int k = 0; k < 16; k++) mem[k] = 8'h00;  // R5
    run_trial();
    chk(cfg_q == '0 && !hold_low, "R5 zero store", cfg_q, '0);
    for (int k = 0; k < 16; k++) mem[k] = 8'($urandom);
    mem[15] = 8'h7F;  // R7: all power-down bits set
    run_trial();
    dual0_in = 1'b1;
    #1;
    chk(osc_off == 1'b1, "R7 osc all down", osc_off, 1);
    mem[15] = 8'h3F;  // R7: one PLL still running
    run_trial();
    dual0_in = 1'b1;
    #1;
    chk(osc_off == 1'b0, "R7 osc one up", osc_off, 0);
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < 16; k++) mem[k] = 8'($urandom) | 8'h01;
      prog_trial();
    end
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule